// File: doc/BRIEF.md
# Cyclic Segment Waveform Generator

This block drives one output bit through a repeating pattern. The pattern is a list of segments, each with an output level and a duration. Both are fixed by parameters when the block is elaborated. The block holds the current segment's level on its output for that segment's duration, then moves to the next segment. After the final segment it starts again at segment zero, and it keeps cycling for as long as it runs. Typical uses are test stimulus, enable strobes and slow status blinkers, all driven from a table compiled into the design.

Time is counted in one of two ways, chosen by a parameter:

- **Clock time base:** one period is one cycle of `clk`.
- **Tick time base:** one period is one rising edge of the `tick_in` input, sampled by `clk`. A slow or irregular signal can therefore set the pace.

Elaboration stops with an error if any segment is shorter than two periods.

Top module: `wavegen`

## Requirements
- R1: While `rst_n` is low, `wave_out` shows the level of segment 0, which is bit 0 of `SEG_LEVELS`. Segment 0 is the first segment played once reset is released.
- R2: In the clock time base, segment i holds level `SEG_LEVELS[i]` on `wave_out` for exactly D(i) clock cycles. D(i) is the unsigned field `SEG_DURS[i*DUR_W +: DUR_W]`, so segment 0 sits in the least significant bits.
- R3: After the last segment (index `NUM_SEG-1`) has run its full duration, the next segment is segment 0. Every pass through the table has the same level and duration sequence.
- R4: In the clock time base, `tick_in` has no effect on `wave_out`.
- R5: In the tick time base, one period is one rising edge of `tick_in`, meaning a sample of 0 followed by a sample of 1 on consecutive clock edges. With `tick_in` high for 2 cycles and low for 2 cycles, segment i lasts 4*D(i) clock cycles.
- R6: In the tick time base, the segment and the output hold their values while `tick_in` shows no rising edge. This holds whether `tick_in` stays low or stays high.
- R7: `wave_out` comes straight from a flip-flop. Moving from one segment to the next adds no extra period, so a high segment of duration N gives exactly N cycles between the output's rising and falling edges.
- R8: Asserting reset partway through the pattern restarts it. After release, the first segment run lasts exactly D(0) periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_in | input | 1 | Pacing input; its rising edges count as periods in the tick time base |
| wave_out | output | 1 | Registered waveform output |

## Verification
The default table alternates levels, so every segment shows up as a separate run of constant output. The bench compares the length and level of each run, over two full passes, with the expected durations:

- **Clock time base, `tick_in` held low:** checks the basic timing and the wrap from the last segment to the first.
- **Clock time base, `tick_in` toggling:** the same checks, and any difference from the first case shows that the pacing input leaks into clock mode.
- **Tick time base, 2-high/2-low input:** every run must be four times longer, which separates true edge counting from level sensing or cycle counting.
- **Tick time base, input held steady:** `tick_in` is held low and then held high. The output must not move, and this catches a detector that counts a level instead of a transition.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

    // Selects what counts as one period of a segment.
    typedef enum logic {
        TB_CLOCK = 1'b0,   // every system clock cycle
        TB_TICK  = 1'b1    // every rising edge seen on the pacing input
    } timebase_e;

endpackage

// File: rtl/wavegen_table.sv
// Combinational lookup of a segment's level and duration by index,
// plus elaboration-time validation of the table contents.
module wavegen_table #(
    parameter int                      NUM_SEG    = 6,
    parameter int                      DUR_W      = 8,
    parameter logic [NUM_SEG-1:0]      SEG_LEVELS = '0,
    parameter logic [NUM_SEG*DUR_W-1:0] SEG_DURS  = '0,
    localparam int                     IDX_W      = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic [IDX_W-1:0] idx,
    output logic             lvl,
    output logic [DUR_W-1:0] dur
);

    // Reject tables that cannot work: empty, or any segment shorter than two periods.
    if (NUM_SEG < 1) begin : g_empty
        $error("wavegen_table: segment list must not be empty");
    end

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_chk
        if (SEG_DURS[g*DUR_W +: DUR_W] < 2) begin : g_short
            $error("wavegen_table: segment %0d is shorter than two periods", g);
        end
    end

    always_comb begin
        lvl = SEG_LEVELS[0];
        dur = SEG_DURS[DUR_W-1:0];
        for (int i = 0; i < NUM_SEG; i++) begin
            if (idx == IDX_W'(i)) begin
                lvl = SEG_LEVELS[i];
                dur = SEG_DURS[i*DUR_W +: DUR_W];
            end
        end
    end

endmodule

// File: rtl/wavegen_advance.sv
// Produces the one-cycle "period elapsed" strobe for the chosen time base.
module wavegen_advance
    import wavegen_pkg::*;
#(
    parameter timebase_e TIME_BASE = TB_CLOCK
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic adv
);

    if (TIME_BASE == TB_TICK) begin : g_tick
        logic prev_d, prev_q;

        always_comb begin
            prev_d = tick_in;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= prev_d;
        end

        // Rising edge: low on the previous sample, high on this one.
        assign adv = tick_in & ~prev_q;
    end else begin : g_clock
        logic unused_tick;
        logic unused_rst;
        logic unused_clk;
        assign unused_tick = tick_in;
        assign unused_rst  = rst_n;
        assign unused_clk  = clk;
        assign adv         = 1'b1;
    end

endmodule

// File: rtl/wavegen.sv
// Cyclic segment waveform generator: top level.
module wavegen
    import wavegen_pkg::*;
#(
    parameter int                       NUM_SEG    = 6,
    parameter int                       DUR_W      = 8,
    parameter logic [NUM_SEG-1:0]       SEG_LEVELS = 6'b101010,
    parameter logic [NUM_SEG*DUR_W-1:0] SEG_DURS   = {8'd6, 8'd2, 8'd5, 8'd4, 8'd2, 8'd3},
    parameter timebase_e                TIME_BASE  = TB_CLOCK
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic wave_out
);

    localparam int IDX_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SEG - 1);
    localparam logic [DUR_W-1:0] TERM_CNT = DUR_W'(1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;   // segment currently playing
        logic [DUR_W-1:0] cnt;   // periods left in this segment, 1 = last
        logic             lvl;   // registered output level
    } state_t;

    localparam state_t ST_RST = '{
        idx: '0,
        cnt: SEG_DURS[DUR_W-1:0],
        lvl: SEG_LEVELS[0]
    };

    state_t           st_d, st_q;
    logic             adv;
    logic [IDX_W-1:0] nxt_idx;
    logic             nxt_lvl;
    logic [DUR_W-1:0] nxt_dur;

    wavegen_advance #(
        .TIME_BASE (TIME_BASE)
    ) u_adv (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_in (tick_in),
        .adv     (adv)
    );

    // Index of the segment that follows the current one, wrapping at the end.
    assign nxt_idx = (st_q.idx == LAST_IDX) ? '0 : st_q.idx + IDX_W'(1);

    wavegen_table #(
        .NUM_SEG    (NUM_SEG),
        .DUR_W      (DUR_W),
        .SEG_LEVELS (SEG_LEVELS),
        .SEG_DURS   (SEG_DURS)
    ) u_tbl (
        .idx (nxt_idx),
        .lvl (nxt_lvl),
        .dur (nxt_dur)
    );

    always_comb begin
        st_d = st_q;
        if (adv) begin
            if (st_q.cnt == TERM_CNT) begin
                // Boundary: next segment's level and full duration load together.
                st_d.idx = nxt_idx;
                st_d.cnt = nxt_dur;
                st_d.lvl = nxt_lvl;
            end else begin
                st_d.cnt = st_q.cnt - DUR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign wave_out = st_q.lvl;

endmodule

// File: rtl/wavegen_chk.sv
// Property checker for wavegen, attached by bind.
module wavegen_chk #(
    parameter int                       NUM_SEG    = 6,
    parameter int                       DUR_W      = 8,
    parameter logic [NUM_SEG-1:0]       SEG_LEVELS = '0,
    parameter logic [NUM_SEG*DUR_W-1:0] SEG_DURS   = '0,
    localparam int                      IDX_W      = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adv,
    input logic [IDX_W-1:0] idx,
    input logic [DUR_W-1:0] cnt,
    input logic             wave_out
);

    logic [DUR_W-1:0] cur_dur;
    logic             cur_lvl;

    always_comb begin
        cur_dur = '0;
        cur_lvl = 1'b0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (idx == IDX_W'(i)) begin
                cur_dur = SEG_DURS[i*DUR_W +: DUR_W];
                cur_lvl = SEG_LEVELS[i];
            end
        end
    end

    // R1: a clock edge seen in reset leaves segment 0 and its level in place
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (idx == '0 && wave_out == SEG_LEVELS[0] && cnt == SEG_DURS[DUR_W-1:0]));

    // R2: the remaining count stays within the current segment's duration
    a_r2_count_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= DUR_W'(1) && cnt <= cur_dur && idx < IDX_W'(NUM_SEG)));

    // R3: the final period of the last segment is followed by segment 0
    a_r3_wrap_to_first: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && idx == IDX_W'(NUM_SEG - 1) && cnt == DUR_W'(1))
        |=> (idx == '0 && wave_out == SEG_LEVELS[0]));

    // R6: without an elapsed period nothing moves
    a_r6_hold_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(wave_out) && $stable(idx) && $stable(cnt)));

    // R7: the output always carries the level of the segment being played
    a_r7_level_from_table: assert property (@(posedge clk) disable iff (!rst_n)
        wave_out == cur_lvl);

    // R7: a segment boundary loads the full next duration, no extra period
    a_r7_boundary_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt == DUR_W'(1)) |=> (cnt == cur_dur && $changed(idx)));

endmodule

bind wavegen wavegen_chk #(
    .NUM_SEG    (NUM_SEG),
    .DUR_W      (DUR_W),
    .SEG_LEVELS (SEG_LEVELS),
    .SEG_DURS   (SEG_DURS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .idx      (st_q.idx),
    .cnt      (st_q.cnt),
    .wave_out (wave_out)
);

// File: tb/tb_wavegen.sv
module tb_wavegen;
    import wavegen_pkg::*;

    localparam int NSEG  = 6;
    localparam int DW    = 8;
    localparam int WD_NS = 200000 * 10;

    // Bench's own copy of the intended table (segment 0 first).
    localparam int   EXP_DUR [NSEG] = '{3, 2, 4, 5, 2, 6};
    localparam logic EXP_LVL [NSEG] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    localparam logic [NSEG-1:0]    P_LVL = 6'b101010;
    localparam logic [NSEG*DW-1:0] P_DUR = {8'd6, 8'd2, 8'd5, 8'd4, 8'd2, 8'd3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic wave_clk, wave_tick;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    wavegen #(
        .NUM_SEG (NSEG), .DUR_W (DW), .SEG_LEVELS (P_LVL), .SEG_DURS (P_DUR),
        .TIME_BASE (TB_CLOCK)
    ) dut (
        .clk (clk), .rst_n (rst_n), .tick_in (tick), .wave_out (wave_clk)
    );

    wavegen #(
        .NUM_SEG (NSEG), .DUR_W (DW), .SEG_LEVELS (P_LVL), .SEG_DURS (P_DUR),
        .TIME_BASE (TB_TICK)
    ) dut_tick (
        .clk (clk), .rst_n (rst_n), .tick_in (tick), .wave_out (wave_tick)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reset taken mid-pattern; both outputs must show segment 0's level (R1).
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick  = 1'b0;
        repeat (3) @(negedge clk);
        check(wave_clk  == EXP_LVL[0], "R1", "clock dut level in reset", wave_clk, EXP_LVL[0]);
        check(wave_tick == EXP_LVL[0], "R1", "tick dut level in reset", wave_tick, EXP_LVL[0]);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Measures consecutive constant-output runs over two table passes.
    task automatic run_check(input bit use_tick_dut, input int scale,
                             input bit drive_tick, input bit skip_first,
                             input string tag);
        int   phase = 0;
        int   runs  = 0;
        int   len   = 1;
        int   guard = 0;
        logic cur, smp;
        tick = drive_tick && ((phase % 4) < 2);
        phase++;
        cur = use_tick_dut ? wave_tick : wave_clk;
        while (runs < 2 * NSEG + 1 && guard < 4000) begin
            @(negedge clk);
            tick = drive_tick && ((phase % 4) < 2);
            phase++;
            guard++;
            smp = use_tick_dut ? wave_tick : wave_clk;
            if (smp == cur) begin
                len++;
            end else begin
                int seg = runs % NSEG;
                check(cur == EXP_LVL[seg], tag, $sformatf("level of run %0d", runs),
                      cur, EXP_LVL[seg]);
                if (!(runs == 0 && skip_first)) begin
                    check(len == scale * EXP_DUR[seg],
                          (runs == 0) ? {tag, " R8"} : ((runs >= NSEG) ? {tag, " R3"} : tag),
                          $sformatf("length of run %0d (segment %0d)", runs, seg),
                          len, scale * EXP_DUR[seg]);
                end
                runs++;
                cur = smp;
                len = 1;
            end
        end
        check(guard < 4000, tag, "runs completed before cycle limit", guard, 4000);
        tick = 1'b0;
    endtask

    // R2 R7 R8: clock time base with a quiet pacing input.
    task automatic test_clock_mode();
        do_reset();
        run_check(1'b0, 1, 1'b0, 1'b0, "R2 R7");
    endtask

    // R4: clock time base while the pacing input toggles.
    task automatic test_clock_ignores_tick();
        do_reset();
        run_check(1'b0, 1, 1'b1, 1'b0, "R4");
    endtask

    // R5: tick time base, input high 2 cycles and low 2 cycles.
    task automatic test_tick_mode();
        do_reset();
        run_check(1'b1, 4, 1'b1, 1'b1, "R5");
    endtask

    // R6: steady pacing input (low, then high) never advances the pattern.
    task automatic test_tick_stall();
        int changes = 0;
        logic first;
        do_reset();
        first = wave_tick;
        repeat (30) begin
            @(negedge clk);
            if (wave_tick != first) changes++;
        end
        check(changes == 0, "R6", "output changes with tick held low", changes, 0);
        tick = 1'b1;   // single rising edge: 3 periods left become 2, still segment 0
        repeat (30) begin
            @(negedge clk);
            if (wave_tick != first) changes++;
        end
        check(changes == 0, "R6", "output changes with tick held high", changes, 0);
        check(wave_tick == EXP_LVL[0], "R6", "level after steady tick", wave_tick, EXP_LVL[0]);
        tick = 1'b0;
    endtask

    initial begin
        test_clock_mode();
        repeat (7) @(negedge clk);          // stop mid-pattern before the next reset
        test_clock_ignores_tick();
        test_tick_mode();
        test_tick_stall();
        test_clock_mode();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(WD_NS);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule